// File: doc/BRIEF.md
# Interrupt Status Register with Learned Polarity

This block gathers seven external interrupt request pins and two internal interrupt sources into one read-only 16-bit status word on a simple register read port. Each external pin may be wired active-high or active-low. The block learns which one applies by sampling the pin's synchronised level while reset is held. That level is taken as the line's idle level. After reset, any line whose synchronised level differs from its idle level is active.

Active external lines are gated by a per-line enable input. They are reported as ones together with the two internal sources, so software always sees active-one status whatever the wiring. The learned idle levels are readable in the low bits of the same word. Reads are a single-cycle strobe, and the data appears on the output after the next clock edge. Writes are accepted on the bus and discarded.

Top module: `irq_status_top`

## Requirements
- R1: Each external pin passes through a two-flop synchroniser. A pin change set up before clock edge N is not seen by a read captured at edge N or N+1. It is seen by a read captured at edge N+2 or later.
- R2: While `rst_n` is low, the idle level of each external line follows its synchronised pin. It is frozen at the value held on the last reset cycle and stays there until the next reset.
- R3: Word bits 6..0 hold the idle levels of external lines 7..1, so line k is at bit k-1. A value of 0 means the line is active high and 1 means it is active low.
- R4: Word bits 14..8 report external lines 7..1, so line k is at bit k+7. A bit reads 1 only when its enable (`irq_en[k-1]`) is 1 and the synchronised pin differs from the stored idle level.
- R5: A line whose enable is 0 reads as 0 in bits 14..8, whatever its pin level.
- R6: Bit 15 reports the internal timer source and bit 7 reports the internal serial-controller source. Each reads 1 when asserted and 0 when not, and neither depends on `irq_en`.
- R7: `rd_data` is loaded with the status word at every clock edge where `rd_stb` is 1. It holds its value at every edge where `rd_stb` is 0.
- R8: A write (`wr_stb` with any `wr_data`) changes neither `rd_data` nor any state seen by later reads.
- R9: During reset and after it, until the first read, `rd_data` is all zeros, so the interrupt-state bits 15..7 read 0.
- R10: A second reset with different idle pin levels relearns every line's polarity, and the status follows the new polarities.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; idle levels are learned while it is low |
| irq_pin | input | 7 | External request pins, bit k-1 is line k, asynchronous |
| irq_en | input | 7 | Per-line enable, bit k-1 is line k |
| tmr_irq | input | 1 | Internal timer interrupt, synchronous, 1 = asserted |
| ser_irq | input | 1 | Internal serial-controller interrupt, synchronous, 1 = asserted |
| rd_stb | input | 1 | Read strobe; data is loaded at the edge where it is high |
| wr_stb | input | 1 | Write strobe; ignored |
| wr_data | input | 16 | Write data; ignored |
| rd_data | output | 16 | Status word, valid the cycle after a read strobe |

## Verification
On every cycle, the assertions check several properties. The idle levels stay frozen outside reset. A read returns the idle levels, the internal sources and only enabled external bits. `rd_data` holds between reads, even when writes arrive. `rd_data` is cleared by reset.

The bench's scenarios cover the rest. Exhaustive sweeps over every pin pattern under several enable masks and learned polarities show the polarity normalisation itself. The two-edge synchroniser latency shows only in a timed scenario, as does relearning across a second reset.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned EXT_LINES = 7;
  localparam int unsigned WORD_W    = 2 * EXT_LINES + 2;

  typedef logic [EXT_LINES-1:0] ext_vec_t;
  typedef logic [WORD_W-1:0]    word_t;

  // Bit positions software decodes in the status word
  localparam int unsigned TMR_BIT      = WORD_W - 1;
  localparam int unsigned EXT_STAT_LSB = EXT_LINES + 1;
  localparam int unsigned SER_BIT      = EXT_LINES;
  localparam int unsigned IDLE_LSB     = 0;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned N      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] pin_async,
  output logic [N-1:0] pin_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [N-1:0] stage_q [STAGES];

  // No reset: the chain must run while reset is held so idle levels settle
  always_ff @(posedge clk) begin
    stage_q[0] <= pin_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[LAST];
endmodule

// File: rtl/irq_polarity.sv
module irq_polarity #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_sync,
  input  logic [N-1:0] line_en,
  output logic [N-1:0] idle_lvl,
  output logic [N-1:0] active
);
  logic [N-1:0] idle_q;

  // Track the pin while in reset; freeze on release
  always_ff @(posedge clk) begin
    if (!rst_n) idle_q <= lvl_sync;
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      active[i] = line_en[i] & (lvl_sync[i] ^ idle_q[i]);
    end
  end

  assign idle_lvl = idle_q;

  // R2: idle levels frozen outside reset
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(idle_q));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rd_stb,
  input  logic     wr_stb,
  input  word_t    wr_data,
  input  ext_vec_t ext_active,
  input  ext_vec_t idle_lvl,
  input  logic     tmr_irq,
  input  logic     ser_irq,
  output word_t    rd_data
);
  word_t status_w;
  word_t rd_q;
  logic  wr_seen;

  always_comb begin
    status_w = '0;
    status_w[TMR_BIT]                            = tmr_irq;
    status_w[EXT_STAT_LSB +: EXT_LINES]          = ext_active;
    status_w[SER_BIT]                            = ser_irq;
    status_w[IDLE_LSB +: EXT_LINES]              = idle_lvl;
  end

  // Writes are decoded only to be dropped
  assign wr_seen = wr_stb & |{wr_data, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_stb) rd_q <= status_w;
  end

  assign rd_data = rd_q;

  // R3: idle field of a read matches the stored idle levels
  p_idle_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rd_q[IDLE_LSB +: EXT_LINES] == idle_lvl));
  // R6: internal sources reported as sampled
  p_internal_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> (rd_q[TMR_BIT] == $past(tmr_irq)) && (rd_q[SER_BIT] == $past(ser_irq)));
  // R7: data holds without a read strobe
  p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && rst_n) |=> $stable(rd_q));
  // R8: a write alone leaves read data untouched
  p_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_seen && !rd_stb && rst_n) |=> $stable(rd_q));
  // R9: reset clears the read data
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |=> (rd_q == '0));
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top
  import irq_status_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  irq_pin,
  input  logic [6:0]  irq_en,
  input  logic        tmr_irq,
  input  logic        ser_irq,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  ext_vec_t pin_sync;
  ext_vec_t idle_lvl;
  ext_vec_t ext_active;

  irq_pin_sync #(.N(EXT_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .pin_async(irq_pin),
    .pin_sync (pin_sync)
  );

  irq_polarity #(.N(EXT_LINES)) u_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_sync(pin_sync),
    .line_en (irq_en),
    .idle_lvl(idle_lvl),
    .active  (ext_active)
  );

  irq_status_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .ext_active(ext_active),
    .idle_lvl  (idle_lvl),
    .tmr_irq   (tmr_irq),
    .ser_irq   (ser_irq),
    .rd_data   (rd_data)
  );

  // R5: disabled lines never read as set
  p_disabled_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((rd_data[EXT_STAT_LSB +: EXT_LINES] & ~$past(irq_en)) == '0));
  // R4: a line at its idle level never reads as set
  p_idle_not_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> ((rd_data[EXT_STAT_LSB +: EXT_LINES] & ~($past(pin_sync) ^ idle_lvl)) == '0));
endmodule

// File: tb/irq_status_top_tb.sv
module irq_status_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_pin = '0;
  logic [6:0]  irq_en = '0;
  logic        tmr_irq = 1'b0;
  logic        ser_irq = 1'b0;
  logic        rd_stb = 1'b0;
  logic        wr_stb = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_top u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .irq_en(irq_en),
    .tmr_irq(tmr_irq), .ser_irq(ser_irq), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic t, input logic s,
      input logic [6:0] pins, input logic [6:0] idle, input logic [6:0] en);
    return {t, (pins ^ idle) & en, s, idle};
  endfunction

  task automatic do_reset(input logic [6:0] idle);
    @(negedge clk);
    irq_pin = idle;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [6:0] idles [4];
    logic [6:0] ens [4];
    idles[0] = 7'h00; idles[1] = 7'h7F; idles[2] = 7'h55; idles[3] = 7'h2A;
    ens[0] = 7'h7F; ens[1] = 7'h00; ens[2] = 7'h33; ens[3] = 7'h4C;

    // R9: reset state, internal sources held high during reset
    tmr_irq = 1'b1; ser_irq = 1'b1;
    do_reset(7'h00);
    check("R9 read data zero after reset", rd_data, 16'h0000);
    tmr_irq = 1'b0; ser_irq = 1'b0;

    // R2 R3 R4 R5 R10: sweep polarity sets across repeated resets
    for (int p = 0; p < 4; p++) begin
      do_reset(idles[p]);
      check("R9 zero after each reset", rd_data, 16'h0000);
      irq_en = 7'h7F;
      do_read(v);
      check("R3 R10 idle field relearned", v, expect_word(1'b0, 1'b0, idles[p], idles[p], 7'h7F));
      for (int e = 0; e < 4; e++) begin
        irq_en = ens[e];
        for (int pin = 0; pin < 128; pin++) begin
          irq_pin = 7'(pin);
          settle();
          do_read(v);
          check("R4 R5 status sweep", v, expect_word(1'b0, 1'b0, 7'(pin), idles[p], ens[e]));
        end
      end
      // R2: pin toggling after reset leaves idle levels unchanged
      irq_pin = ~idles[p];
      settle();
      do_read(v);
      check("R2 idle frozen after reset", {9'h0, v[6:0]}, {9'h0, idles[p]});
    end

    // R10: explicit second reset flipping one line
    do_reset(7'h00);
    irq_en = 7'h7F; irq_pin = 7'h01;
    settle(); do_read(v);
    check("R10 line1 active-high", v, expect_word(1'b0, 1'b0, 7'h01, 7'h00, 7'h7F));
    do_reset(7'h01);
    irq_pin = 7'h01;
    settle(); do_read(v);
    check("R10 line1 relearned active-low idle", v, expect_word(1'b0, 1'b0, 7'h01, 7'h01, 7'h7F));
    irq_pin = 7'h00;
    settle(); do_read(v);
    check("R10 line1 active when low", v, expect_word(1'b0, 1'b0, 7'h00, 7'h01, 7'h7F));

    // R6: internal sources, all four combinations, with enables off
    irq_en = 7'h00;
    for (int c = 0; c < 4; c++) begin
      tmr_irq = c[1]; ser_irq = c[0];
      do_read(v);
      check("R6 internal sources", v, expect_word(c[1], c[0], 7'h00, 7'h01, 7'h00));
    end
    tmr_irq = 1'b0; ser_irq = 1'b0;

    // R7 R8: writes without reads leave rd_data and state alone
    irq_en = 7'h7F; irq_pin = 7'h40;
    settle(); do_read(v);
    check("R7 baseline read", v, expect_word(1'b0, 1'b0, 7'h40, 7'h01, 7'h7F));
    @(negedge clk);
    irq_pin = 7'h01;
    wr_stb = 1'b1; wr_data = 16'hFFFF;
    repeat (3) @(negedge clk);
    wr_data = 16'h0000;
    @(negedge clk);
    wr_stb = 1'b0;
    check("R7 R8 rd_data held through writes", rd_data, expect_word(1'b0, 1'b0, 7'h40, 7'h01, 7'h7F));
    do_read(v);
    check("R8 state unchanged after writes", v, expect_word(1'b0, 1'b0, 7'h01, 7'h01, 7'h7F));

    // R1: synchroniser latency, strobe held across three edges
    irq_pin = 7'h00;
    settle(); do_read(v);
    @(negedge clk);
    irq_pin = 7'h10; rd_stb = 1'b1;
    @(negedge clk);
    check("R1 edge N old value", rd_data, expect_word(1'b0, 1'b0, 7'h00, 7'h01, 7'h7F));
    @(negedge clk);
    check("R1 edge N+1 old value", rd_data, expect_word(1'b0, 1'b0, 7'h00, 7'h01, 7'h7F));
    @(negedge clk);
    rd_stb = 1'b0;
    check("R1 edge N+2 new value", rd_data, expect_word(1'b0, 1'b0, 7'h10, 7'h01, 7'h7F));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule